// File: doc/BRIEF.md
# Path-History Indirect Target Predictor

This block predicts the destination of indirect branches from the route the program took to reach them. It keeps a 15-bit path register that folds in a small signature of each recent taken conditional branch and each indirect branch, two bit positions at a time. Older branches drift out of the top after about eight qualifying branches. Each indirect branch is looked up in a 256-entry direct-mapped target table. The table is addressed by a cross-wired XOR of the branch address and the path register, and the same hash supplies the entry's tag.

Fetch presents a lookup address, together with the hit flag from the main target buffer. The block answers in the same cycle with a hit flag and a predicted target. Resolved branches come back on a retire port, one per cycle. For a retiring indirect branch, the block rebuilds the hash from the path value held before that retire. It rewrites the entry whenever the entry was missing or held a different target. On the same clock edge it advances the path register. The path register is also driven out, so that a global direction predictor can share it.

Top module: `ind_tgt_pred`

## Requirements
- R1: After reset the path register reads zero and no lookup reports a hit.
- R2: A retired conditional branch with taken=1 (kind code 2'b00) sets the path to its old value shifted left two places, upper two bits dropped, XOR address bits [18:4].
- R3: A retired indirect branch (kind code 2'b10) sets the path to its old value shifted left two places XOR a 15-bit word. That word has bits [14:13] zero, bits [12:6] equal to address bits [18:12] and bits [5:0] equal to target bits [5:0].
- R4: A not-taken conditional branch, a direct jump (kind 2'b01) and a call or return (kind 2'b11) leave the path register unchanged.
- R5: The 15-bit hash H is formed as follows. H[13:6] = address[11:4] XOR path[13:6]. H[14] = address[12] XOR path[14]. H[5:0] = address[18:13] XOR path[5:0]. The table index is H[13:6], and the tag is {H[14], H[5:0]}.
- R6: A hit is reported only when the lookup is valid, the main target buffer hit input is high, and the indexed entry is valid with a matching tag. Without a hit, the target output is zero.
- R7: After an indirect branch retires, its entry holds that branch's tag and target, so a later lookup under the same hash predicts the new target.
- R8: The table is direct-mapped. An indirect branch with the same index but a different tag replaces the older entry, and the older branch then misses.
- R9: A lookup and a retire in the same cycle both use the path value from before that retire. The updated path is seen from the next cycle on.
- R10: The current path register is driven on path_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request valid |
| lk_pc_i | input | ADDR_W | Lookup branch address |
| lk_btb_hit_i | input | 1 | Main target buffer hit for the lookup |
| rt_valid_i | input | 1 | Retired branch valid |
| rt_kind_i | input | 2 | 00 conditional, 01 direct jump, 10 indirect, 11 call/return |
| rt_taken_i | input | 1 | Resolved direction of a conditional branch |
| rt_pc_i | input | ADDR_W | Retired branch address |
| rt_tgt_i | input | TGT_W | Retired branch resolved target |
| pred_hit_o | output | 1 | Prediction available |
| pred_tgt_o | output | TGT_W | Predicted target |
| path_o | output | 15 | Path register for sharing |

## Verification
A corrupt path register shows on path_o one cycle after the retire that produced it. It also moves every later hash, so lookups that should hit begin to miss, or return another branch's target. A wrong hash wiring shows as a miss when a crafted path/address pair should alias onto a known entry. A stale or wrongly tagged table entry shows at the next lookup under the same hash, in the same cycle the lookup is presented, because the read path is combinational.

// File: rtl/ind_pred_pkg.sv
package ind_pred_pkg;
  localparam int PATH_W  = 15;
  localparam int IDX_W   = 8;
  localparam int TAG_W   = PATH_W - IDX_W;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int SIG_LSB = 4;
  localparam int SIG_MSB = SIG_LSB + PATH_W - 1;

  typedef enum logic [1:0] {
    BR_COND    = 2'b00,
    BR_JMP     = 2'b01,
    BR_IND     = 2'b10,
    BR_CALLRET = 2'b11
  } br_kind_e;
endpackage

// File: rtl/ind_path_reg.sv
module ind_path_reg
  import ind_pred_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rt_valid_i,
  input  logic [1:0]        rt_kind_i,
  input  logic              rt_taken_i,
  input  logic [PATH_W-1:0] rt_sig_i,   // address bits [18:4]
  input  logic [5:0]        rt_tlo_i,   // target bits [5:0]
  output logic [PATH_W-1:0] path_o
);
  logic [PATH_W-1:0] path_q, path_d, shifted, mix;
  logic sel_cond, sel_ind;

  assign sel_cond = rt_valid_i && (br_kind_e'(rt_kind_i) == BR_COND) && rt_taken_i;
  assign sel_ind  = rt_valid_i && (br_kind_e'(rt_kind_i) == BR_IND);
  assign shifted  = {path_q[PATH_W-3:0], 2'b00};

  always_comb begin
    mix = '0;
    if (sel_cond)     mix = rt_sig_i;
    else if (sel_ind) mix = {2'b00, rt_sig_i[PATH_W-1:8], rt_tlo_i};
  end

  always_comb begin
    path_d = path_q;
    if (sel_cond || sel_ind) path_d = shifted ^ mix;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) path_q <= '0;
    else         path_q <= path_d;
  end

  assign path_o = path_q;

  assert_one_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel_cond, sel_ind}));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rt_valid_i || rt_kind_i == 2'b01 || rt_kind_i == 2'b11 ||
     (rt_kind_i == 2'b00 && !rt_taken_i)) |=> $stable(path_q));

  assert_ind_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rt_valid_i && rt_kind_i == 2'b10) |=> path_q[5:0] == $past(rt_tlo_i ^ {path_q[3:0], 2'b00}));
endmodule

// File: rtl/ind_hash.sv
module ind_hash
  import ind_pred_pkg::*;
(
  input  logic [PATH_W-1:0] sig_i,   // address bits [18:4]
  input  logic [PATH_W-1:0] path_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o
);
  logic [PATH_W-1:0] h;
  // cross-wired pairing of address and path bits
  assign h[13:6] = sig_i[7:0]  ^ path_i[13:6];
  assign h[14]   = sig_i[8]    ^ path_i[14];
  assign h[5:0]  = sig_i[14:9] ^ path_i[5:0];

  assign idx_o = h[13:6];
  assign tag_o = {h[14], h[5:0]};
endmodule

// File: rtl/ind_tgt_table.sv
module ind_tgt_table
  import ind_pred_pkg::*;
#(
  parameter int TGT_W = 32,
  parameter int NRD   = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NRD-1:0][IDX_W-1:0]  ridx_i,
  input  logic [NRD-1:0][TAG_W-1:0]  rtag_i,
  output logic [NRD-1:0]             rhit_o,
  output logic [NRD-1:0][TGT_W-1:0]  rtgt_o,
  input  logic                       we_i,
  input  logic [IDX_W-1:0]           widx_i,
  input  logic [TAG_W-1:0]           wtag_i,
  input  logic [TGT_W-1:0]           wtgt_i
);
  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [TGT_W-1:0]   tgt_q [ENTRIES];

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rhit_o[p] = vld_q[ridx_i[p]] && (tag_q[ridx_i[p]] == rtag_i[p]);
    assign rtgt_o[p] = tgt_q[ridx_i[p]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   vld_q <= '0;
    else if (we_i) vld_q[widx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      tag_q[widx_i] <= wtag_i;
      tgt_q[widx_i] <= wtgt_i;
    end
  end

  assert_alloc_vld_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> vld_q[$past(widx_i)]);

  assert_alloc_tgt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> tgt_q[$past(widx_i)] == $past(wtgt_i));
endmodule

// File: rtl/ind_tgt_pred.sv
module ind_tgt_pred
  import ind_pred_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TGT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [ADDR_W-1:0] lk_pc_i,
  input  logic              lk_btb_hit_i,
  input  logic              rt_valid_i,
  input  logic [1:0]        rt_kind_i,
  input  logic              rt_taken_i,
  input  logic [ADDR_W-1:0] rt_pc_i,
  input  logic [TGT_W-1:0]  rt_tgt_i,
  output logic              pred_hit_o,
  output logic [TGT_W-1:0]  pred_tgt_o,
  output logic [PATH_W-1:0] path_o
);
  localparam int LK = 0;
  localparam int RT = 1;

  logic [PATH_W-1:0]      path;
  logic [PATH_W-1:0]      lk_sig, rt_sig;
  logic [1:0][IDX_W-1:0]  idx;
  logic [1:0][TAG_W-1:0]  tag;
  logic [1:0]             hit;
  logic [1:0][TGT_W-1:0]  tgt;
  logic                   rt_ind, tbl_we;

  assign lk_sig = lk_pc_i[SIG_MSB:SIG_LSB];
  assign rt_sig = rt_pc_i[SIG_MSB:SIG_LSB];

  ind_path_reg u_path (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rt_valid_i (rt_valid_i),
    .rt_kind_i  (rt_kind_i),
    .rt_taken_i (rt_taken_i),
    .rt_sig_i   (rt_sig),
    .rt_tlo_i   (rt_tgt_i[5:0]),
    .path_o     (path)
  );

  ind_hash u_hash_lk (.sig_i(lk_sig), .path_i(path), .idx_o(idx[LK]), .tag_o(tag[LK]));
  ind_hash u_hash_rt (.sig_i(rt_sig), .path_i(path), .idx_o(idx[RT]), .tag_o(tag[RT]));

  // rewrite only on miss or wrong target
  assign rt_ind = rt_valid_i && (br_kind_e'(rt_kind_i) == BR_IND);
  assign tbl_we = rt_ind && (!hit[RT] || tgt[RT] != rt_tgt_i);

  ind_tgt_table #(.TGT_W(TGT_W), .NRD(2)) u_tbl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ridx_i (idx),
    .rtag_i (tag),
    .rhit_o (hit),
    .rtgt_o (tgt),
    .we_i   (tbl_we),
    .widx_i (idx[RT]),
    .wtag_i (tag[RT]),
    .wtgt_i (rt_tgt_i)
  );

  assign pred_hit_o = lk_valid_i && lk_btb_hit_i && hit[LK];
  assign pred_tgt_o = pred_hit_o ? tgt[LK] : '0;
  assign path_o     = path;

  logic unused_bits;
  assign unused_bits = ^{lk_pc_i[ADDR_W-1:SIG_MSB+1], lk_pc_i[SIG_LSB-1:0],
                         rt_pc_i[ADDR_W-1:SIG_MSB+1], rt_pc_i[SIG_LSB-1:0]};

  assert_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_hit_o |-> (lk_valid_i && lk_btb_hit_i));

  assert_wr_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_we |-> (rt_valid_i && rt_kind_i == 2'b10));

  assert_path_lag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rt_valid_i |=> $stable(path_o));
endmodule

// File: tb/tb_ind_tgt_pred.sv
`timescale 1ns/1ps
module tb_ind_tgt_pred;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_btb = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        rt_valid = 1'b0, rt_taken = 1'b0;
  logic [1:0]  rt_kind = '0;
  logic [31:0] rt_pc = '0, rt_tgt = '0;
  logic        pred_hit;
  logic [31:0] pred_tgt;
  logic [14:0] path;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  ind_tgt_pred dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_pc_i(lk_pc), .lk_btb_hit_i(lk_btb),
    .rt_valid_i(rt_valid), .rt_kind_i(rt_kind), .rt_taken_i(rt_taken),
    .rt_pc_i(rt_pc), .rt_tgt_i(rt_tgt),
    .pred_hit_o(pred_hit), .pred_tgt_o(pred_tgt), .path_o(path)
  );

  // model state
  logic [14:0] mpath = '0;
  logic        mv   [256];
  logic [6:0]  mtag [256];
  logic [31:0] mtgt [256];

  function automatic logic [14:0] m_next(logic [14:0] p, logic [1:0] k, logic t,
                                         logic [31:0] pc, logic [31:0] tg);
    logic [14:0] s;
    s = {p[12:0], 2'b00};
    if (k == 2'd0 && t) return s ^ pc[18:4];
    if (k == 2'd2)      return s ^ {2'b00, pc[18:12], tg[5:0]};
    return p;
  endfunction

  function automatic logic [7:0] m_idx(logic [31:0] pc, logic [14:0] p);
    return pc[11:4] ^ p[13:6];
  endfunction

  function automatic logic [6:0] m_tag(logic [31:0] pc, logic [14:0] p);
    return {pc[12] ^ p[14], pc[18:13] ^ p[5:0]};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // retire one branch; lookup the same address in that cycle (old path, R9)
  task automatic do_retire(logic [1:0] k, logic t, logic [31:0] pc, logic [31:0] tg);
    logic [7:0] ix;
    logic [6:0] tgv;
    logic eh;
    logic [14:0] np;
    string rq;
    @(negedge clk);
    rt_valid = 1'b1; rt_kind = k; rt_taken = t; rt_pc = pc; rt_tgt = tg;
    lk_valid = 1'b1; lk_btb = 1'b1; lk_pc = pc;
    #1;
    ix = m_idx(pc, mpath);
    tgv = m_tag(pc, mpath);
    eh = mv[ix] && mtag[ix] == tgv;
    chk(pred_hit == eh, "R9 lookup hit with pre-retire path", {31'd0, pred_hit}, {31'd0, eh});
    if (eh) chk(pred_tgt == mtgt[ix], "R9 lookup target", pred_tgt, mtgt[ix]);
    if (k == 2'd2) begin
      mv[ix] = 1'b1; mtag[ix] = tgv; mtgt[ix] = tg;
    end
    np = m_next(mpath, k, t, pc, tg);
    rq = (k == 2'd0 && t) ? "R2 taken cond path" : (k == 2'd2) ? "R3 indirect path" : "R4 path hold";
    mpath = np;
    @(posedge clk);
    #1;
    rt_valid = 1'b0; lk_valid = 1'b0; lk_btb = 1'b0;
    chk(path == np, rq, {17'd0, path}, {17'd0, np});
  endtask

  task automatic clear_path();
    for (int i = 0; i < 8; i++) do_retire(2'd0, 1'b1, 32'h0, 32'h0);
  endtask

  task automatic look(logic [31:0] pc, logic btb, logic v, logic eh, logic [31:0] et, string req);
    @(negedge clk);
    lk_pc = pc; lk_btb = btb; lk_valid = v;
    #1;
    chk(pred_hit == eh, req, {31'd0, pred_hit}, {31'd0, eh});
    chk(pred_tgt == et, req, pred_tgt, et);
    lk_valid = 1'b0; lk_btb = 1'b0;
  endtask

  // {kind, taken, pc, target}
  localparam logic [66:0] VEC [16] = '{
    {2'd0, 1'b1, 32'h0001_2340, 32'h0000_0000},
    {2'd2, 1'b1, 32'h0004_5670, 32'h1000_0024},
    {2'd0, 1'b0, 32'h0000_7770, 32'h0000_0000},
    {2'd2, 1'b1, 32'h0007_1230, 32'h2000_003C},
    {2'd1, 1'b1, 32'h0003_3330, 32'h0000_9000},
    {2'd0, 1'b1, 32'h0006_0010, 32'h0000_0000},
    {2'd3, 1'b1, 32'h0002_0200, 32'h0000_4000},
    {2'd2, 1'b1, 32'h0004_5670, 32'h3000_0011},
    {2'd2, 1'b1, 32'h0004_5670, 32'h3000_0011},
    {2'd0, 1'b1, 32'h0000_0FF0, 32'h0000_0000},
    {2'd2, 1'b1, 32'h0001_0100, 32'h4000_0008},
    {2'd0, 1'b0, 32'h0005_5550, 32'h0000_0000},
    {2'd2, 1'b1, 32'h0007_FFF0, 32'h5000_003F},
    {2'd0, 1'b1, 32'h0007_FFF0, 32'h0000_0000},
    {2'd3, 1'b0, 32'h0000_1110, 32'h0000_0000},
    {2'd2, 1'b1, 32'h0002_2220, 32'h6000_0002}
  };

  initial begin
    for (int i = 0; i < 256; i++) begin mv[i] = 1'b0; mtag[i] = '0; mtgt[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk(path == 15'd0, "R1 path after reset", {17'd0, path}, 32'd0);
    chk(path == 15'd0, "R10 path_o reflects register", {17'd0, path}, 32'd0);
    look(32'h0000_0120, 1'b1, 1'b1, 1'b0, 32'd0, "R1 no hit after reset");

    for (int i = 0; i < 16; i++)
      do_retire(VEC[i][66:65], VEC[i][64], VEC[i][63:32], VEC[i][31:0]);

    // R2 literal values
    clear_path();
    do_retire(2'd0, 1'b1, 32'h0007_FFF0, 32'h0);
    chk(path == 15'h7FFF, "R2 first shift-xor", {17'd0, path}, 32'h7FFF);
    do_retire(2'd0, 1'b1, 32'h0007_FFF0, 32'h0);
    chk(path == 15'h0003, "R2 top bits dropped", {17'd0, path}, 32'h0003);
    // R3 literal
    clear_path();
    do_retire(2'd2, 1'b1, 32'h0007_F000, 32'h0000_003F);
    chk(path == 15'h1FFF, "R3 indirect mix", {17'd0, path}, 32'h1FFF);
    // R4 holds
    do_retire(2'd0, 1'b0, 32'h0007_FFF0, 32'h0);
    do_retire(2'd1, 1'b1, 32'h0007_FFF0, 32'h0);
    do_retire(2'd3, 1'b1, 32'h0007_FFF0, 32'h0);
    chk(path == 15'h1FFF, "R4 no change", {17'd0, path}, 32'h1FFF);

    // R5 hash aliasing: entry written at path 0, pc 0x120
    clear_path();
    do_retire(2'd2, 1'b1, 32'h0000_0120, 32'hAAAA_0000);
    clear_path();
    do_retire(2'd0, 1'b1, 32'h0000_0400, 32'h0);   // path = 0x0040
    look(32'h0000_0130, 1'b1, 1'b1, 1'b1, 32'hAAAA_0000, "R5 index bits alias");
    clear_path();
    do_retire(2'd0, 1'b1, 32'h0000_0010, 32'h0);   // path = 0x0001
    look(32'h0000_2120, 1'b1, 1'b1, 1'b1, 32'hAAAA_0000, "R5 low tag bits alias");
    clear_path();
    do_retire(2'd0, 1'b1, 32'h0004_0000, 32'h0);   // path = 0x4000
    look(32'h0000_1120, 1'b1, 1'b1, 1'b1, 32'hAAAA_0000, "R5 tag bit 14 alias");

    // R6 gating
    clear_path();
    look(32'h0000_0120, 1'b1, 1'b1, 1'b1, 32'hAAAA_0000, "R6 hit with btb hit");
    look(32'h0000_0120, 1'b0, 1'b1, 1'b0, 32'd0, "R6 no btb hit");
    look(32'h0000_0120, 1'b1, 1'b0, 1'b0, 32'd0, "R6 lookup not valid");

    // R8 replacement in same set
    do_retire(2'd2, 1'b1, 32'h0000_2120, 32'hBBBB_0000);
    clear_path();
    look(32'h0000_0120, 1'b1, 1'b1, 1'b0, 32'd0, "R8 old branch evicted");
    look(32'h0000_2120, 1'b1, 1'b1, 1'b1, 32'hBBBB_0000, "R8 new branch present");

    // R7 retarget
    do_retire(2'd2, 1'b1, 32'h0000_2120, 32'hCCCC_0000);
    clear_path();
    look(32'h0000_2120, 1'b1, 1'b1, 1'b1, 32'hCCCC_0000, "R7 new target learned");

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule